// File: doc/BRIEF.md
# Receive FIFO Trigger and Timeout Detector

This block watches the fill level of a 16-entry receive FIFO and produces the two receive-side conditions that an interrupt controller consumes. The first is a threshold flag: software picks one of four fill levels with a 2-bit code, and the flag is high while the FIFO holds at least that many characters. A copy of the flag, gated by the data-available interrupt enable, is also provided.

The second condition is an inactivity timeout. The block counts character-time ticks, which are generated elsewhere from the baud rate and frame length. It declares a timeout when four ticks pass with characters waiting and no push or pop in that time. Any push or pop restarts the count, and an empty FIFO holds it at zero. A pending timeout stays set until the receive buffer is read. This lets software collect a short tail of characters that never reaches the threshold.

All three outputs are registered. Reset is asserted asynchronously and released through a synchronizer.

Top module: `rx_trig_tmo`

## Requirements
- R1: While `rst_n` is low, `trig_hit`, `rda_irq` and `tmo_pend` are 0. After release they stay 0 until a condition below sets them.
- R2: `trig_sel` selects the threshold: 2'b00 means 1 character, 2'b01 means 4, 2'b10 means 8 and 2'b11 means 14. After a clock edge at which `fifo_level` is at or above the threshold, `trig_hit` is 1.
- R3: After a clock edge at which `fifo_level` is below the selected threshold, `trig_hit` is 0.
- R4: After each edge, `rda_irq` equals the value `trig_hit` takes at that edge ANDed with the `rda_en` sampled at that edge.
- R5: `tmo_pend` becomes 1 after the edge that samples the fourth `char_tick` since the last push or pop, provided `fifo_level` was non-zero and there was no push or pop at each edge in between.
- R6: A `fifo_push` or `fifo_pop` at an edge restarts the tick count from zero. A `char_tick` at that same edge is not counted.
- R7: A tick sampled while `fifo_level` is 0 is not counted, and it resets the count. No timeout is raised while the FIFO is empty.
- R8: `rbr_read` at an edge makes `tmo_pend` 0 after that edge. This holds even if a timeout would be declared at the same edge.
- R9: Once set, `tmo_pend` stays 1 until `rbr_read`. Pushes, pops and further ticks do not clear it. After a timeout, no new timeout is declared until a push or pop restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fifo_level | input | 5 | Number of characters in the receive FIFO (0 to 16) |
| fifo_push | input | 1 | One-cycle strobe: a character is written into the FIFO |
| fifo_pop | input | 1 | One-cycle strobe: a character is removed from the FIFO |
| trig_sel | input | 2 | Threshold code: 00 means 1, 01 means 4, 10 means 8, 11 means 14 |
| char_tick | input | 1 | One-cycle strobe, once per character time |
| rbr_read | input | 1 | One-cycle strobe: the receive buffer is read |
| rda_en | input | 1 | Data-available interrupt enable |
| trig_hit | output | 1 | FIFO level is at or above the threshold |
| rda_irq | output | 1 | `trig_hit` gated by `rda_en` |
| tmo_pend | output | 1 | Character timeout pending |

## Verification
The assertions assume that the FIFO presented to the block is consistent. `fifo_level` never exceeds 16, a push never arrives while the FIFO is full, and a pop never arrives while it is empty. They also assume that `fifo_level` changes only by the net of the push and pop strobes of the previous cycle. The stimulus keeps within these rules because the bench keeps its own occupancy model and draws each push and pop from `$urandom` only when that model allows it. The directed sequences for thresholds and timeouts are built from the same legal push, pop and tick steps.

// File: rtl/rxtt_pkg.sv
package rxtt_pkg;

  // Threshold in characters for each 2-bit trigger code.
  function automatic int unsigned trig_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxtt_rst_sync.sv
module rxtt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rxtt_thresh.sv
module rxtt_thresh
  import rxtt_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       sel,
  input  logic             rda_en,
  output logic             hit,
  output logic             rda_irq
);

  logic [3:0] hit_by_code;
  logic       hit_d;
  logic       irq_d;
  logic       hit_q;
  logic       irq_q;

  // One comparator per trigger code; the code only drives the final mux.
  for (genvar k = 0; k < 4; k++) begin : g_cmp
    assign hit_by_code[k] = (level >= LVL_W'(trig_bytes(2'(k))));
  end

  always_comb begin
    hit_d = hit_by_code[sel];
    irq_d = hit_d & rda_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
      irq_q <= irq_d;
    end
  end

  assign hit     = hit_q;
  assign rda_irq = irq_q;

endmodule

// File: rtl/rxtt_idle_timer.sv
module rxtt_idle_timer #(
  parameter int LVL_W     = 5,
  parameter int TMO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             push,
  input  logic             pop,
  input  logic             char_tick,
  input  logic             rbr_read,
  output logic             tmo_pend
);

  localparam int TMO_W = $clog2(TMO_CHARS + 1);
  localparam logic [TMO_W-1:0] CNT_LAST = TMO_W'(TMO_CHARS - 1);
  localparam logic [TMO_W-1:0] CNT_FULL = TMO_W'(TMO_CHARS);

  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] cnt_d;
  logic             cnt_en;
  logic             flag_q;
  logic             flag_d;
  logic             flag_en;
  logic             restart;
  logic             expire;

  always_comb begin
    restart = push | pop | (level == '0);
    expire  = !restart && char_tick && (cnt_q == CNT_LAST);
    // The count saturates at CNT_FULL, so a timeout is declared once per quiet period.
    cnt_en  = restart | (char_tick && (cnt_q != CNT_FULL));
    cnt_d   = restart ? '0 : cnt_q + TMO_W'(1);
    // A read clears the flag and wins over a timeout at the same edge.
    flag_en = rbr_read | expire;
    flag_d  = !rbr_read;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign tmo_pend = flag_q;

endmodule

// File: rtl/rx_trig_tmo.sv
module rx_trig_tmo #(
  parameter int DEPTH       = 16,
  parameter int TMO_CHARS   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_push,
  input  logic             fifo_pop,
  input  logic [1:0]       trig_sel,
  input  logic             char_tick,
  input  logic             rbr_read,
  input  logic             rda_en,
  output logic             trig_hit,
  output logic             rda_irq,
  output logic             tmo_pend
);

  logic rst_sn;

  rxtt_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sn)
  );

  rxtt_thresh #(
    .LVL_W (LVL_W)
  ) u_thresh (
    .clk     (clk),
    .rst_n   (rst_sn),
    .level   (fifo_level),
    .sel     (trig_sel),
    .rda_en  (rda_en),
    .hit     (trig_hit),
    .rda_irq (rda_irq)
  );

  rxtt_idle_timer #(
    .LVL_W     (LVL_W),
    .TMO_CHARS (TMO_CHARS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sn),
    .level     (fifo_level),
    .push      (fifo_push),
    .pop       (fifo_pop),
    .char_tick (char_tick),
    .rbr_read  (rbr_read),
    .tmo_pend  (tmo_pend)
  );

endmodule

// File: rtl/rxtt_chk.sv
module rxtt_chk #(
  parameter int LVL_W     = 5,
  parameter int TMO_CHARS = 4
) (
  input logic             clk,
  input logic             rst_ok,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_push,
  input logic             fifo_pop,
  input logic             char_tick,
  input logic             rbr_read,
  input logic             rda_en,
  input logic             trig_hit,
  input logic             rda_irq,
  input logic             tmo_pend
);

  localparam int TMO_W = $clog2(TMO_CHARS + 1);

  // Quiet-tick count seen at the ports, saturating at TMO_CHARS.
  logic [TMO_W-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) quiet_q <= '0;
    else if (fifo_push || fifo_pop || fifo_level == '0) quiet_q <= '0;
    else if (char_tick && quiet_q != TMO_W'(TMO_CHARS)) quiet_q <= quiet_q + TMO_W'(1);
  end

  // R2
  deep_trig_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (fifo_level >= LVL_W'(14)) |=> trig_hit);

  // R3
  empty_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (fifo_level == '0) |=> !trig_hit);

  // R4
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !rda_en |=> !rda_irq);

  // R5
  tmo_window_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(tmo_pend) |-> ($past(quiet_q) == TMO_W'(TMO_CHARS - 1)));

  // R6
  quiet_edge_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(tmo_pend) |-> $past(!fifo_push && !fifo_pop && char_tick));

  // R7
  empty_no_tmo_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(tmo_pend) |-> $past(fifo_level != '0));

  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rbr_read |=> !tmo_pend);

  // R9
  tmo_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (tmo_pend && !rbr_read) |=> tmo_pend);

endmodule

bind rx_trig_tmo rxtt_chk #(
  .LVL_W     (LVL_W),
  .TMO_CHARS (TMO_CHARS)
) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sn),
  .fifo_level (fifo_level),
  .fifo_push  (fifo_push),
  .fifo_pop   (fifo_pop),
  .char_tick  (char_tick),
  .rbr_read   (rbr_read),
  .rda_en     (rda_en),
  .trig_hit   (trig_hit),
  .rda_irq    (rda_irq),
  .tmo_pend   (tmo_pend)
);

// File: tb/sim_rx_trig_tmo.sv
`timescale 1ns/1ps
module sim_rx_trig_tmo;

  localparam int DEPTH = 16;
  localparam int TMO   = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] fifo_level;
  logic       fifo_push, fifo_pop, char_tick, rbr_read, rda_en;
  logic [1:0] trig_sel;
  logic       trig_hit, rda_irq, tmo_pend;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Bench model state
  int lvl   = 0;
  int m_cnt = 0;
  bit m_tmo = 0;
  int sel   = 0;
  bit en    = 0;

  always #2.5 clk = ~clk;

  rx_trig_tmo u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_level (fifo_level),
    .fifo_push  (fifo_push),
    .fifo_pop   (fifo_pop),
    .trig_sel   (trig_sel),
    .char_tick  (char_tick),
    .rbr_read   (rbr_read),
    .rda_en     (rda_en),
    .trig_hit   (trig_hit),
    .rda_irq    (rda_irq),
    .tmo_pend   (tmo_pend)
  );

  function automatic int thr(input int s);
    case (s)
      0:       return 1;
      1:       return 4;
      2:       return 8;
      default: return 14;
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b (level %0d sel %0d)", tag, act, exp, lvl, sel);
    end
  endtask

  // Drive one cycle at a falling edge and check the outputs at the next falling edge.
  task automatic step(input bit p, input bit q, input bit t, input bit rd,
                      input string ttag, input string ktag);
    bit e_trig, e_irq, restart, expire;
    fifo_level = 5'(lvl);
    fifo_push  = p;
    fifo_pop   = q;
    char_tick  = t;
    rbr_read   = rd;
    trig_sel   = 2'(sel);
    rda_en     = en;
    e_trig  = (lvl >= thr(sel));
    e_irq   = e_trig & en;
    restart = (lvl == 0) || p || q;
    expire  = !restart && t && (m_cnt == TMO - 1);
    if (restart) m_cnt = 0;
    else if (t && m_cnt < TMO) m_cnt++;
    if (rd) m_tmo = 0;
    else if (expire) m_tmo = 1;
    @(posedge clk);
    @(negedge clk);
    check(trig_hit, e_trig, ttag);
    check(rda_irq, e_irq, "R4");
    check(tmo_pend, m_tmo, ktag);
    lvl = lvl + int'(p) - int'(q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h51C0);
    rst_n = 1'b0;
    fifo_level = '0; fifo_push = 0; fifo_pop = 0; char_tick = 0;
    rbr_read = 0; rda_en = 0; trig_sel = '0;
    repeat (3) @(negedge clk);
    // R1: outputs low in reset, even with inputs that would set them
    fifo_level = 5'd15; rda_en = 1; char_tick = 1;
    @(negedge clk);
    check(trig_hit, 1'b0, "R1");
    check(rda_irq, 1'b0, "R1");
    check(tmo_pend, 1'b0, "R1");
    fifo_level = '0; rda_en = 0; char_tick = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(trig_hit, 1'b0, "R1");
    check(tmo_pend, 1'b0, "R1");

    // R2 / R3: fill and drain at each threshold code
    for (int s = 0; s < 4; s++) begin
      sel = s; en = s[0];
      for (int i = 0; i < 14; i++) step(1, 0, 0, 0, "R2", "R6");
      for (int i = 0; i < 14; i++) step(0, 1, 0, 1, "R3", "R6");
    end

    // R5: two characters, four quiet ticks
    sel = 3; en = 1;
    step(1, 0, 0, 0, "R2", "R7");
    step(1, 0, 0, 0, "R2", "R6");
    for (int i = 0; i < TMO; i++) step(0, 0, 1, 0, "R3", "R5");
    // R9: activity and ticks do not clear the flag
    step(1, 0, 1, 0, "R3", "R9");
    step(0, 1, 1, 0, "R3", "R9");
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, "R3", "R9");
    // R8: read without pop clears
    step(0, 0, 0, 1, "R3", "R8");
    // R6: push in the middle restarts the count
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R3", "R6");
    step(1, 0, 1, 0, "R3", "R6");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R3", "R6");
    step(0, 0, 1, 0, "R3", "R5");
    step(0, 1, 0, 1, "R3", "R8");
    // R8: read at the edge where a timeout would be declared
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R3", "R6");
    step(0, 0, 1, 1, "R3", "R8");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "R3", "R9");
    // R7: drain, then ticks on an empty FIFO
    while (lvl > 0) step(0, 1, 0, 1, "R3", "R7");
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0, "R3", "R7");

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      bit p, q, t, rd;
      if (i % 64 == 0) begin
        sel = int'($urandom % 4);
        en  = bit'($urandom % 2);
      end
      p  = (lvl < DEPTH) && ($urandom % 10 == 0);
      q  = (lvl > 0) && ($urandom % 9 == 0);
      t  = ($urandom % 3 == 0);
      rd = q ? 1'b1 : ($urandom % 40 == 0);
      step(p, q, t, rd, "R2", "R5");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule